// File: doc/BRIEF.md
# Decode-Stage Branch and Fetch-PC Controller

This block owns the fetch program counter of a five-stage in-order pipeline and settles conditional branches and direct jumps while they sit in the decode stage. Decode presents the instruction class, the two register operands it has read, the register numbers those operands came from, a sign-extended word offset and a 26-bit jump index. An equality comparator and the target adders run in the same cycle. A taken branch or a jump therefore steers fetch at the very next clock edge. The branch then rides down the rest of the pipe as an idle instruction.

The architecture has exactly one delay slot. The word that is being fetched while a branch or jump is in decode always executes, whatever the branch decides. The controller never squashes it, and no flush output exists.

A conditional branch can need a register that an older instruction has not yet produced. This happens when the producer is in execute, or when it is a load that is still in execute or memory. In that case the branch waits in decode and the fetch address is frozen until the value can be forwarded. The pipeline moves one instruction per cycle and has no back-pressure other than this stall, so every pin is a plain control or data level with no valid/ready pairing. `dec_valid` marks that decode holds a real instruction, and `stall` is the only hold signal the block raises toward fetch.

Top module: `branch_pc_unit`

## Requirements
- R1: While reset is low, and on the first cycle after reset is released, `fetch_pc` is 0.
- R2: `dec_op` uses 0 for a non-control instruction. In that case, or when `dec_valid` is low, `stall` and `redirect` stay low and `fetch_pc` advances by 4 on each edge.
- R3: `dec_op` uses 1 for branch-if-equal. When the operands are equal and there is no hazard, `redirect` is high and the next `fetch_pc` is the current `fetch_pc` plus `dec_offset` shifted left by 2. Otherwise the next `fetch_pc` is the current value plus 4.
- R4: `dec_op` uses 2 for branch-if-not-equal. It is taken under the same target rule as R3 when the operands differ.
- R5: `dec_op` uses 3 for a jump, which is always taken. The next `fetch_pc` is the top 4 bits of the current `fetch_pc`, then `dec_index`, then two zero bits.
- R6: In the cycle a branch or jump is in decode, `fetch_pc` already holds the delay-slot address, which is the branch address plus 4. The redirect only changes the address fetched after that slot, so a taken control transfer costs no cycle beyond the slot.
- R7: A valid conditional branch raises `stall` in the following cases:
  - `ex_wr_en` is set and `ex_dst` is nonzero and equals `dec_rs` or `dec_rt`.
  - `mem_load` is set and `mem_dst` is nonzero and equals either source register.

  While `stall` is high, `redirect` is low and `fetch_pc` holds its value.
- R8: A jump never raises `stall`, whatever the hazard inputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_op | input | 2 | Instruction class: 0 other, 1 branch-equal, 2 branch-not-equal, 3 jump |
| dec_rs | input | REG_AW | Register number of operand A |
| dec_rt | input | REG_AW | Register number of operand B |
| opnd_a | input | DATA_W | First compared operand |
| opnd_b | input | DATA_W | Second compared operand |
| dec_offset | input | PC_W | Sign-extended branch word offset |
| dec_index | input | IDX_W | Jump word index |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_dst | input | REG_AW | Destination of the instruction in execute |
| mem_load | input | 1 | Instruction in memory stage is a load |
| mem_dst | input | REG_AW | Destination of the load in memory stage |
| fetch_pc | output | PC_W | Address fetched this cycle |
| redirect | output | 1 | Control transfer taken; next fetch goes to the target |
| stall | output | 1 | Hold fetch and the branch in decode |

## Verification
The bench builds the block with 4-bit operands and 3-bit register numbers, and keeps the 32-bit address and 26-bit jump index. This small setting lets it sweep every pair of operand values under both conditional kinds. It also sweeps every combination of the two source registers against every destination, for the execute-stage writer and again for the memory-stage load, and that combination sweep includes register 0. Jumps are driven with hazard inputs that point at their own source fields, and with address upper bits that have wrapped. The bench computes every expected address with its own arithmetic from the current address it has tracked.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_BEQ   = 2'd1,
    OP_BNE   = 2'd2,
    OP_JMP   = 2'd3
  } br_op_e;
endpackage

// File: rtl/bru_compare.sv
module bru_compare #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              same
);
  // Reduce the bitwise difference: one XOR level and an OR tree.
  logic [DATA_W-1:0] diff;
  assign diff = lhs ^ rhs;
  assign same = ~|diff;
endmodule

// File: rtl/bru_hazard.sv
module bru_hazard #(
  parameter int REG_AW = 5
) (
  input  logic              need_regs,
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] mem_dst,
  output logic              hold
);
  localparam int NPROD = 2;

  logic [NPROD-1:0]  live;
  logic [REG_AW-1:0] dst [NPROD];
  logic [NPROD-1:0]  hit;

  assign live[0] = ex_wr_en;
  assign live[1] = mem_load;
  assign dst[0]  = ex_dst;
  assign dst[1]  = mem_dst;

  for (genvar g = 0; g < NPROD; g++) begin : g_prod
    // Register 0 is never a real producer.
    assign hit[g] = live[g] && (dst[g] != '0) && ((dst[g] == src_a) || (dst[g] == src_b));
  end

  assign hold = need_regs && (|hit);
endmodule

// File: rtl/bru_next_pc.sv
module bru_next_pc #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 26
) (
  input  logic [PC_W-1:0]  slot_pc,
  input  logic [PC_W-1:0]  offset,
  input  logic [IDX_W-1:0] index,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  br_pc,
  output logic [PC_W-1:0]  jmp_pc
);
  localparam int HI_W = PC_W - IDX_W - 2;

  assign seq_pc = slot_pc + PC_W'(4);
  assign br_pc  = slot_pc + (offset << 2);
  assign jmp_pc = {slot_pc[PC_W-1 -: HI_W], index, 2'b00};
endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import bru_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 26,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [1:0]        dec_op,
  input  logic [REG_AW-1:0] dec_rs,
  input  logic [REG_AW-1:0] dec_rt,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [PC_W-1:0]   dec_offset,
  input  logic [IDX_W-1:0]  dec_index,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] mem_dst,
  output logic [PC_W-1:0]   fetch_pc,
  output logic              redirect,
  output logic              stall
);
  br_op_e          op;
  logic            is_cond, is_jmp, same, cond_hit, hold;
  logic [PC_W-1:0] pc_q, pc_d, seq_pc, br_pc, jmp_pc;

  assign op      = br_op_e'(dec_op);
  assign is_cond = dec_valid && ((op == OP_BEQ) || (op == OP_BNE));
  assign is_jmp  = dec_valid && (op == OP_JMP);

  bru_compare #(.DATA_W(DATA_W)) cmp_i (
    .lhs (opnd_a),
    .rhs (opnd_b),
    .same(same)
  );

  bru_hazard #(.REG_AW(REG_AW)) haz_i (
    .need_regs(is_cond),
    .src_a    (dec_rs),
    .src_b    (dec_rt),
    .ex_wr_en (ex_wr_en),
    .ex_dst   (ex_dst),
    .mem_load (mem_load),
    .mem_dst  (mem_dst),
    .hold     (hold)
  );

  // pc_q is the delay-slot address while a control op sits in decode.
  bru_next_pc #(.PC_W(PC_W), .IDX_W(IDX_W)) npc_i (
    .slot_pc(pc_q),
    .offset (dec_offset),
    .index  (dec_index),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc)
  );

  assign cond_hit = (op == OP_BEQ) ? same : !same;
  assign stall    = hold;
  assign redirect = !hold && ((is_cond && cond_hit) || is_jmp);

  always_comb begin
    if (hold)                pc_d = pc_q;
    else if (is_jmp)         pc_d = jmp_pc;
    else if (is_cond && cond_hit) pc_d = br_pc;
    else                     pc_d = seq_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign fetch_pc = pc_q;
endmodule

// File: rtl/branch_pc_unit_chk.sv
module branch_pc_unit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic [1:0]      dec_op,
  input logic [PC_W-1:0] fetch_pc,
  input logic            redirect,
  input logic            stall
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) !rst_n |=> fetch_pc == '0);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetch_pc));

  // R7
  stall_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !redirect);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect) |=> fetch_pc == $past(fetch_pc) + PC_W'(4));

  // R8
  jump_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_op == 2'd3) |-> !stall);

  // R5
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_op == 2'd3) |=> fetch_pc[PC_W-1 -: 4] == $past(fetch_pc[PC_W-1 -: 4]));

  // R2
  idle_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid || dec_op == 2'd0) |-> !redirect);
endmodule

bind branch_pc_unit branch_pc_unit_chk #(.PC_W(PC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .dec_valid(dec_valid),
  .dec_op   (dec_op),
  .fetch_pc (fetch_pc),
  .redirect (redirect),
  .stall    (stall)
);

// File: tb/branch_pc_unit_tb_top.sv
module branch_pc_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, IDX_W = 26, DATA_W = 4, REG_AW = 3;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              dec_valid = 0;
  logic [1:0]        dec_op = 0;
  logic [REG_AW-1:0] dec_rs = 0, dec_rt = 0, ex_dst = 0, mem_dst = 0;
  logic [DATA_W-1:0] opnd_a = 0, opnd_b = 0;
  logic [PC_W-1:0]   dec_offset = 0;
  logic [IDX_W-1:0]  dec_index = 0;
  logic              ex_wr_en = 0, mem_load = 0;
  logic [PC_W-1:0]   fetch_pc;
  logic              redirect, stall;

  int checks = 0, errors = 0;
  logic [PC_W-1:0] exp_pc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_pc_unit #(.PC_W(PC_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_rs(dec_rs), .dec_rt(dec_rt), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .dec_offset(dec_offset), .dec_index(dec_index), .ex_wr_en(ex_wr_en),
    .ex_dst(ex_dst), .mem_load(mem_load), .mem_dst(mem_dst),
    .fetch_pc(fetch_pc), .redirect(redirect), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input logic [PC_W-1:0] act,
                     input logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge: drive, check, clock, check the new address.
  task automatic step(input logic v, input logic [1:0] op,
                      input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                      input logic [PC_W-1:0] off, input logic [IDX_W-1:0] idx,
                      input logic [REG_AW-1:0] rs, input logic [REG_AW-1:0] rt,
                      input logic exw, input logic [REG_AW-1:0] exd,
                      input logic ml, input logic [REG_AW-1:0] md, input string tag);
    logic cond, haz, tk;
    logic [PC_W-1:0] nxt;
    dec_valid = v; dec_op = op; opnd_a = a; opnd_b = b; dec_offset = off;
    dec_index = idx; dec_rs = rs; dec_rt = rt; ex_wr_en = exw; ex_dst = exd;
    mem_load = ml; mem_dst = md;
    #1;
    cond = v && (op == 2'd1 || op == 2'd2);
    haz  = cond && ((exw && exd != 0 && (exd == rs || exd == rt)) ||
                    (ml && md != 0 && (md == rs || md == rt)));
    tk   = v && !haz && ((op == 2'd1 && a == b) || (op == 2'd2 && a != b) || op == 2'd3);
    if (haz)                  nxt = exp_pc;
    else if (v && op == 2'd3) nxt = {exp_pc[31:28], idx, 2'b00};
    else if (tk)              nxt = exp_pc + (off << 2);
    else                      nxt = exp_pc + 4;
    // R6: the delay-slot address is on fetch_pc while the control op decodes
    chk(fetch_pc == exp_pc, "R6", fetch_pc, exp_pc);
    // R7 / R8: stall level
    chk(stall == haz, (v && op == 2'd3) ? "R8" : "R7", PC_W'(stall), PC_W'(haz));
    chk(redirect == tk, tag, PC_W'(redirect), PC_W'(tk));
    @(posedge clk); @(negedge clk);
    exp_pc = nxt;
    chk(fetch_pc == nxt, tag, fetch_pc, nxt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: held in reset
    chk(fetch_pc == 0, "R1", fetch_pc, 0);
    rst_n = 1;
    #1;
    // R1: first cycle after release
    chk(fetch_pc == 0, "R1", fetch_pc, 0);
    exp_pc = 0;

    // R2: plain instructions and invalid slots advance by 4
    for (int i = 0; i < 12; i++)
      step(1'b1, 2'd0, 4'(i), 4'(i), 32'(i), 26'(i), 3'(i), 3'(i + 1),
           1'b1, 3'(i), 1'b1, 3'(i + 1), "R2");
    for (int i = 0; i < 8; i++)
      step(1'b0, 2'(i % 4), 4'd5, 4'd5, 32'd40, 26'h123, 3'd1, 3'd2,
           1'b0, 3'd0, 1'b0, 3'd0, "R2");

    // R3 / R4: full operand sweep for both conditional kinds
    for (int op = 1; op <= 2; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          step(1'b1, 2'(op), 4'(a), 4'(b), 32'(a * 16 + b - 130), 26'd0,
               3'd1, 3'd2, 1'b0, 3'd0, 1'b0, 3'd0, (op == 1) ? "R3" : "R4");

    // R5 / R8: jumps, hazard inputs pointing at the source fields
    for (int i = 0; i < 24; i++)
      step(1'b1, 2'd3, 4'd0, 4'd1, 32'd0, 26'(i * 2796203 + 7), 3'(i), 3'(i + 3),
           1'b1, 3'(i), 1'b1, 3'(i + 3), "R5");

    // R3 after a jump into a high region: upper bits come from the slot address
    step(1'b1, 2'd3, 4'd0, 4'd0, 32'd0, 26'h3FFFFFF, 3'd0, 3'd0,
         1'b0, 3'd0, 1'b0, 3'd0, "R5");
    step(1'b1, 2'd1, 4'd3, 4'd3, 32'd2, 26'd0, 3'd0, 3'd0,
         1'b0, 3'd0, 1'b0, 3'd0, "R3");
    step(1'b1, 2'd3, 4'd0, 4'd0, 32'd0, 26'h0000010, 3'd0, 3'd0,
         1'b0, 3'd0, 1'b0, 3'd0, "R5");

    // R7: execute-stage writer sweep, then memory-stage load sweep
    for (int pass = 0; pass < 2; pass++)
      for (int rs = 0; rs < 8; rs++)
        for (int rt = 0; rt < 8; rt++)
          for (int d = 0; d < 8; d++)
            step(1'b1, 2'(1 + ((rs + d) % 2)), 4'(rt), 4'(d), 32'(d - 3), 26'd0,
                 3'(rs), 3'(rt), pass == 0, 3'(d), pass == 1, 3'(d), "R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule